// File: doc/BRIEF.md
# Paged Open-Drain Digital I/O Port

This block puts 48 open-drain I/O lines, grouped as six 8-bit ports, behind a small byte-wide register interface. Each bit of a port register controls one line. A 1 makes the line sink current and go low. A 0 releases it, so an external pull-up holds it high and the line can serve as an input. A read of a port returns the inverted level seen on the lines, so a released, undisturbed line reads as 0 and a line held low reads as 1. Line levels pass through a two-flop synchronizer before they reach the read path.

A single control byte holds a 2-bit page field and one write-lock bit per port. The page decides what the three-byte window above the ports reaches. On page 0 the window is dead. On pages 1 to 3 it forwards reads and writes to an attached edge-detect/interrupt unit, which provides the registers behind the window. A status byte from that unit is readable at a fixed offset on every page. The port registers are also reachable on every page.

Top module: `pdio_port`

## Requirements
- R1: A write to offset 0x00–0x05 (port n = offset) of an unlocked port loads the byte into that port. Bit k of port n drives `pin_drive_low_o[8n+k]`, where 1 means the line is pulled low and 0 means high-Z. The output changes on the clock edge that takes the write.
- R2: A read of offset 0x00–0x05 returns the bitwise inverse of port n's line levels as seen through a two-flop synchronizer. Read data appears on `bus_rdata_o` in the cycle after the read strobe.
- R3: The port offsets 0x00–0x05 behave the same for reads and writes whatever the page field holds.
- R4: Offset 0x07 is the control byte. Bits 7:6 hold the page (0–3) and bit n of bits 5:0 is the write lock of port n. Writes load it and reads return it.
- R5: While a port's lock bit is 1, writes to that port leave its drive outputs unchanged. Reads of that port still return its inverted line levels.
- R6: On pages 1–3, an access to offset 0x08–0x0A is forwarded to the interrupt unit. `pg_wr_o` or `pg_rd_o` is high in the same cycle as the bus strobe, with `pg_idx_o` = offset − 8, `pg_page_o` = page, and `pg_wdata_o` = write data. A read returns `pg_rdata_i` in the following cycle.
- R7: On page 0, reads of offsets 0x08–0x0A return 0x00. Writes to them raise neither `pg_wr_o` nor `pg_rd_o`.
- R8: A read of offset 0x06 returns `irq_pend_i` on every page.
- R9: Reads of offsets 0x0B–0x0F return 0x00. Writes to them change no port and do not change the control byte.
- R10: A synchronous active-low reset clears every port to 0, which releases all lines, and clears the control byte to 0x00 (page 0, no locks).
- R11: In any cycle after a cycle with no read strobe, `bus_rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| pin_in_i | input | 48 | Sampled line levels (asynchronous) |
| pin_drive_low_o | output | 48 | 1 = pull the line low, 0 = high-Z |
| irq_pend_i | input | 8 | Pending status from the interrupt unit |
| pg_page_o | output | 2 | Current page, to the interrupt unit |
| pg_idx_o | output | 2 | Window register index (offset − 8) |
| pg_wr_o | output | 1 | Forwarded window write strobe |
| pg_rd_o | output | 1 | Forwarded window read strobe |
| pg_wdata_o | output | 8 | Forwarded write data |
| pg_rdata_i | input | 8 | Window read data from the interrupt unit, combinational on page and index |

## Verification
The assertions assume that `pg_rdata_i` and `irq_pend_i` are steady during the cycle of a read strobe. They also assume that read and write strobes never arrive together, and that each access is a single-cycle strobe. The bench drives every access as a one-cycle pulse of one strobe, placed on the falling edge. It models the interrupt unit as a combinational function of page and index, and changes the pending status only between accesses. Line levels come from a model of the open-drain pins with an external pull-up. The bench waits out the synchronizer latency before it reads any port whose levels have changed.

// File: rtl/pdio_pkg.sv
// Package: shared offsets and page codes for the paged open-drain I/O block.
// Assumes a 4-bit register offset space; the offsets below are behaviour that
// software relies on and must not move.
package pdio_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_PEND     = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_WIN_LO   = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_WIN_HI   = 4'hA;

    typedef enum logic [1:0] {
        PG_PORT  = 2'd0,
        PG_POLAR = 2'd1,
        PG_ENAB  = 2'd2,
        PG_IDENT = 2'd3
    } page_e;
endpackage

// File: rtl/pdio_sync.sv
// Module: multi-stage synchronizer for asynchronous line levels.
// Assumes STAGES >= 1; every bit is synchronized on its own (no bus coherency).
module pdio_sync #(
    parameter int W      = 48,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    // First stage captures the raw levels.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pdio_pagelock.sv
// Module: control byte holding the page field (bits 7:6) and per-port locks.
// Assumes NUM_PORTS <= 6 so the locks fit below the page field.
module pdio_pagelock
    import pdio_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [7:0]           wdata_i,
    output page_e                page_o,
    output logic [NUM_PORTS-1:0] lock_o,
    output logic [7:0]           ctrl_o
);
    logic [7:0] ctrl_q;

    // Load the whole control byte on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 8'h00;
        else if (wr_en_i) ctrl_q <= wdata_i;
    end

    assign page_o = page_e'(ctrl_q[7:6]);
    assign lock_o = ctrl_q[NUM_PORTS-1:0];
    assign ctrl_o = ctrl_q;

    // R4: a write lands in the control byte on the next edge.
    a_r4_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ctrl_o == $past(wdata_i));
    // R4: without a write the control byte holds.
    a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ctrl_o));
endmodule

// File: rtl/pdio_portbank.sv
// Module: bank of port registers driving open-drain pull-low enables.
// Assumes one write strobe per cycle; a set lock bit blocks writes to its port.
module pdio_portbank #(
    parameter int NUM_PORTS = 6,
    parameter int PORT_W    = 8,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOT_W    = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [PORT_W-1:0]    wdata_i,
    input  logic [NUM_PORTS-1:0] lock_i,
    output logic [TOT_W-1:0]     drive_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] port_q;
        logic              hit;

        assign hit = wr_en_i && (sel_i == SEL_W'(p));

        // Store this port's drive byte unless its lock is set.
        always_ff @(posedge clk) begin
            if (!rst_n)                port_q <= '0;
            else if (hit && !lock_i[p]) port_q <= wdata_i;
        end

        assign drive_o[p*PORT_W +: PORT_W] = port_q;

        // R5: a locked port ignores writes.
        a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && lock_i[p]) |=> $stable(drive_o[p*PORT_W +: PORT_W]));
        // R1: an unlocked write reaches the pins on the next edge.
        a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !lock_i[p]) |=> drive_o[p*PORT_W +: PORT_W] == $past(wdata_i));
    end
endmodule

// File: rtl/pdio_port.sv
// Module: top of the paged open-drain I/O block. Decodes the offset space,
// routes writes to ports / control byte / paged window, and builds the
// registered read data. Assumes single-cycle strobes, never read and write
// together, and PORT_W equal to the 8-bit bus width.
module pdio_port
    import pdio_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOT_W      = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [TOT_W-1:0]  pin_in_i,
    output logic [TOT_W-1:0]  pin_drive_low_o,
    input  logic [7:0]        irq_pend_i,
    output logic [1:0]        pg_page_o,
    output logic [1:0]        pg_idx_o,
    output logic              pg_wr_o,
    output logic              pg_rd_o,
    output logic [7:0]        pg_wdata_o,
    input  logic [7:0]        pg_rdata_i
);
    logic                 port_hit, ctrl_hit, pend_hit, win_hit, win_live;
    page_e                page;
    logic [NUM_PORTS-1:0] lock;
    logic [7:0]           ctrl_byte;
    logic [TOT_W-1:0]     pin_sync;
    logic [PORT_W-1:0]    rb [NUM_PORTS];
    logic [7:0]           rd_next;
    logic [7:0]           rdata_q;

    // Offset decode for the fixed register map.
    always_comb begin
        port_hit = bus_addr_i < ADDR_W'(NUM_PORTS);
        ctrl_hit = bus_addr_i == OFS_CTRL;
        pend_hit = bus_addr_i == OFS_PEND;
        win_hit  = (bus_addr_i >= OFS_WIN_LO) && (bus_addr_i <= OFS_WIN_HI);
        win_live = win_hit && (page != PG_PORT);
    end

    pdio_sync #(.W(TOT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in_i),
        .q_o   (pin_sync)
    );

    pdio_pagelock #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (bus_wr_i && ctrl_hit),
        .wdata_i (bus_wdata_i),
        .page_o  (page),
        .lock_o  (lock),
        .ctrl_o  (ctrl_byte)
    );

    pdio_portbank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (bus_wr_i && port_hit),
        .sel_i   (bus_addr_i[SEL_W-1:0]),
        .wdata_i (bus_wdata_i),
        .lock_i  (lock),
        .drive_o (pin_drive_low_o)
    );

    // Inverted readback byte for every port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rb
        assign rb[p] = ~pin_sync[p*PORT_W +: PORT_W];
    end

    // Forwarding of the paged window to the interrupt unit.
    assign pg_page_o  = page;
    assign pg_idx_o   = bus_addr_i[1:0];
    assign pg_wr_o    = bus_wr_i && win_live;
    assign pg_rd_o    = bus_rd_i && win_live;
    assign pg_wdata_o = bus_wdata_i;

    // Select the byte a read at the current offset returns.
    always_comb begin
        rd_next = 8'h00;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr_i == ADDR_W'(p)) rd_next = rb[p];
        end
        if (pend_hit) rd_next = irq_pend_i;
        if (ctrl_hit) rd_next = ctrl_byte;
        if (win_live) rd_next = pg_rdata_i;
    end

    // Register read data for one cycle; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= 8'h00;
        else if (bus_rd_i) rdata_q <= rd_next;
        else               rdata_q <= 8'h00;
    end

    assign bus_rdata_o = rdata_q;

    // R11: no read strobe means zero data next cycle.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> bus_rdata_o == 8'h00);
    // R8: pending status is readable on any page.
    a_r8_pend_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == OFS_PEND) |=> bus_rdata_o == $past(irq_pend_i));
    // R6: a live window read returns the unit's data.
    a_r6_win_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && win_hit && pg_page_o != 2'd0) |=> bus_rdata_o == $past(pg_rdata_i));
    // R7: window reads on page 0 return zero.
    a_r7_page0_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && win_hit && pg_page_o == 2'd0) |=> bus_rdata_o == 8'h00);
    // R7: nothing is forwarded while page 0 is selected.
    a_r7_page0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_page_o == 2'd0) |-> !(pg_wr_o || pg_rd_o));
endmodule

// File: tb/pdio_port_tb.sv
module pdio_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in;
    logic [47:0] drive;
    logic [47:0] ext_lvl = '1;
    logic [7:0]  irq_pend = '0;
    logic [1:0]  pg_page, pg_idx;
    logic        pg_wr, pg_rd;
    logic [7:0]  pg_wdata, pg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      req_q [$];
    logic       rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line model with pull-up; ext_lvl bit 0 = external driver low.
    assign pin_in   = ~drive & ext_lvl;
    // Interrupt unit model: data is a function of page and index.
    assign pg_rdata = {pg_page, pg_idx, 4'hA};

    pdio_port u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
        .bus_wr_i (bus_wr), .bus_rd_i (bus_rd), .bus_rdata_o (bus_rdata),
        .pin_in_i (pin_in), .pin_drive_low_o (drive),
        .irq_pend_i (irq_pend),
        .pg_page_o (pg_page), .pg_idx_o (pg_idx),
        .pg_wr_o (pg_wr), .pg_rd_o (pg_rd),
        .pg_wdata_o (pg_wdata), .pg_rdata_i (pg_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected byte to the scoreboard.
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); req_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd && rst_n;

    // Monitor: pop and compare each read result one edge after the strobe.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(req_q.pop_front(), {56'h0, bus_rdata}, {56'h0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 drive in reset", {16'h0, drive}, 64'h0);
        rst_n = 1'b1;
        settle();
        rd(4'h7, 8'h00, "R10 ctrl after reset");
        rd(4'h0, 8'h00, "R2 idle line reads 0");

        // R1 drive and R2 inverted readback
        wr(4'h0, 8'hA5);
        check("R1 port0 drive", {56'h0, drive[7:0]}, 64'hA5);
        wr(4'h5, 8'h3C);
        check("R1 port5 drive", {56'h0, drive[47:40]}, 64'h3C);
        settle();
        rd(4'h0, 8'hA5, "R2 port0 readback");
        rd(4'h5, 8'h3C, "R2 port5 readback");
        ext_lvl[15:8] = 8'h0F;
        settle();
        rd(4'h1, 8'hF0, "R2 external low lines");

        // R4 control byte and R3 ports on another page
        wr(4'h7, 8'h80);
        rd(4'h7, 8'h80, "R4 ctrl readback");
        rd(4'h0, 8'hA5, "R3 port read on page 2");
        wr(4'h2, 8'h11);
        check("R3 port write on page 2", {56'h0, drive[23:16]}, 64'h11);

        // R6 window forwarding
        @(negedge clk);
        bus_addr = 4'h9; bus_wdata = 8'h5E; bus_wr = 1'b1;
        #1;
        check("R6 fwd strobe/idx/page/data", {46'h0, pg_wr, pg_rd, pg_idx, pg_page, pg_wdata},
              {46'h0, 1'b1, 1'b0, 2'd1, 2'd2, 8'h5E});
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'hA, 8'hAA, "R6 window read page 2");
        wr(4'h7, 8'hC0);
        rd(4'h8, 8'hCA, "R6 window read page 3");

        // R7 dead window on page 0
        wr(4'h7, 8'h00);
        @(negedge clk);
        bus_addr = 4'h8; bus_wdata = 8'hFF; bus_wr = 1'b1;
        #1;
        check("R7 no forward on page 0", {62'h0, pg_wr, pg_rd}, 64'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'h9, 8'h00, "R7 page 0 window reads 0");

        // R8 pending status
        irq_pend = 8'h05;
        rd(4'h6, 8'h05, "R8 pending on page 0");
        wr(4'h7, 8'h40);
        rd(4'h6, 8'h05, "R8 pending on page 1");
        wr(4'h7, 8'h00);

        // R9 reserved offsets
        rd(4'hB, 8'h00, "R9 offset B reads 0");
        rd(4'hF, 8'h00, "R9 offset F reads 0");
        wr(4'hC, 8'hFF);
        check("R9 reserved write leaves ports", {16'h0, drive}, {16'h0, 8'h3C, 16'h0, 8'h11, 8'h00, 8'hA5});
        rd(4'h7, 8'h00, "R9 reserved write leaves ctrl");

        // R5 locks
        wr(4'h7, 8'h21);
        wr(4'h0, 8'h00);
        check("R5 locked port0 holds", {56'h0, drive[7:0]}, 64'hA5);
        wr(4'h5, 8'hFF);
        check("R5 locked port5 holds", {56'h0, drive[47:40]}, 64'h3C);
        rd(4'h0, 8'hA5, "R5 locked port still readable");
        wr(4'h1, 8'h0F);
        check("R5 unlocked port1 writes", {56'h0, drive[15:8]}, 64'h0F);

        // R11 idle read data
        @(negedge clk);
        check("R11 idle rdata zero", {56'h0, bus_rdata}, 64'h0);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset releases all lines", {16'h0, drive}, 64'h0);
        rst_n = 1'b1;
        ext_lvl = '1;
        settle();
        rd(4'h7, 8'h00, "R10 ctrl cleared by reset");
        rd(4'h0, 8'h00, "R10 port0 released");
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule